// File: doc/BRIEF.md
# Key-Locked Watchdog Reset Timer

This block is a countdown watchdog meant for a power-management device. It can pull the whole system into reset. Software reaches it through four write-only registers on a 2-bit address: a guard register, the two 16-bit halves of a 32-bit reload value, and a control register. The guard register holds a 16-bit password. Until that password is written, the block ignores every write to the reload halves and to control.

Once it is armed, the counter steps down by one on each cycle in which the slow tick input is high. The count only advances while two gate inputs are both high: one enables the block's interface and one enables its working clock. When the countdown runs out and reset-on-expiry is enabled, the block drives a reset pulse whose width is set by a parameter. A typical reboot sequence is: open the guard, load a small value, then set both the run bit and the reset-enable bit in one control write.

Top module: `kwdt_top`

## Requirements
- R1: After `rst_n` is released, `rst_out` is low, the guard is closed, both reload halves are zero, and the run and reset-enable bits are clear.
- R2: A write of 16'hE551 to address 0 opens the guard. A write of any other value to address 0 closes it again.
- R3: While the guard is closed, writes to address 1 (reload low half), address 2 (reload high half) and address 3 (control) change nothing.
- R4: The reload value is {high half, low half}. A control write with bit 1 set loads this value into the counter only if the run bit was clear before the write. If the counter is already running, such a write does not reload it.
- R5: While running with both gates high, each tick lowers the count by one. For a reload value N of 1 or more, the counter expires on the Nth tick after loading. A reload value of 0 expires on the first tick.
- R6: While `mod_en` or `clk_en` is low, ticks are ignored and the count is held. Counting resumes from the held value when both gates are high again.
- R7: When the counter expires with control bit 3 set, `rst_out` goes high on the clock edge after the expiring tick and stays high for exactly PULSE_LEN cycles. When control bit 3 is clear, no pulse is produced.
- R8: A control write with bit 1 clear stops the countdown, and no pulse occurs while the run bit stays clear.
- R9: Each load gives at most one expiry. Further ticks after an expiry produce no new pulse until the counter is loaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 guard, 1 reload low, 2 reload high, 3 control |
| wr_data | input | 16 | Write data |
| tick | input | 1 | Slow time-base enable, one cycle high per count step |
| mod_en | input | 1 | Interface enable gate |
| clk_en | input | 1 | Working-clock enable gate |
| rst_out | output | 1 | System reset request pulse |

## Verification
The hardest case to reach from the ports is the high half of the reload value actually taking part in the countdown. That needs more than 65536 ticks with no stray control write in between. The stimulus loads {1, 2}, drives the tick on every cycle for about 66 thousand cycles, and checks that the pulse is absent in the first window and present in the second. The other hard cases are pausing a live countdown through either gate, and stopping or re-arming it mid-count. These are reached by placing control writes between runs of ticks at chosen points.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  localparam int HALF_W = 16;
  localparam int CNT_W  = 2 * HALF_W;

  localparam int CTRL_RUN_BIT = 1;
  localparam int CTRL_ARM_BIT = 3;

  typedef enum logic [1:0] {
    REG_GUARD   = 2'd0,
    REG_LOAD_LO = 2'd1,
    REG_LOAD_HI = 2'd2,
    REG_CTRL    = 2'd3
  } kwdt_reg_e;

  // Full reload value from its two halves
  function automatic logic [CNT_W-1:0] join_halves(input logic [HALF_W-1:0] hi,
                                                   input logic [HALF_W-1:0] lo);
    return {hi, lo};
  endfunction

  // A step taken at this count is the final one
  function automatic logic is_last_step(input logic [CNT_W-1:0] c);
    return c <= CNT_W'(1);
  endfunction

endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
#(
  parameter logic [HALF_W-1:0] UNLOCK_KEY = 16'hE551
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [HALF_W-1:0] wr_data,
  output logic              unlocked,
  output logic [CNT_W-1:0]  load_val,
  output logic              run,
  output logic              arm,
  output logic              start
);

  logic [HALF_W-1:0] half_q [2];
  logic              cfg_wr;

  assign cfg_wr = wr_en && unlocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
    end else if (wr_en && wr_addr == REG_GUARD) begin
      unlocked <= (wr_data == UNLOCK_KEY);
    end
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam logic [1:0] HALF_ADDR = (h == 0) ? REG_LOAD_LO : REG_LOAD_HI;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        half_q[h] <= '0;
      end else if (cfg_wr && wr_addr == HALF_ADDR) begin
        half_q[h] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      arm <= 1'b0;
    end else if (cfg_wr && wr_addr == REG_CTRL) begin
      run <= wr_data[CTRL_RUN_BIT];
      arm <= wr_data[CTRL_ARM_BIT];
    end
  end

  assign load_val = join_halves(half_q[1], half_q[0]);
  assign start    = cfg_wr && wr_addr == REG_CTRL && wr_data[CTRL_RUN_BIT] && !run;

endmodule

// File: rtl/kwdt_countdown.sv
module kwdt_countdown
  import kwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             run,
  input  logic             gate_ok,
  input  logic             arm,
  output logic [CNT_W-1:0] count,
  output logic             done,
  output logic             expire
);

  logic step;
  logic last;

  assign step   = tick && run && gate_ok && !done && !start;
  assign last   = step && is_last_step(count);
  assign expire = last && arm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      done  <= 1'b0;
    end else if (start) begin
      count <= load_val;
      done  <= 1'b0;
    end else if (last) begin
      count <= '0;
      done  <= 1'b1;
    end else if (step) begin
      count <= count - CNT_W'(1);
    end
  end

endmodule

// File: rtl/kwdt_stretch.sv
module kwdt_stretch #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic pulse
);

  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] LEN = PW'(PULSE_LEN);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (trigger) begin
      left_q <= LEN;
    end else if (left_q != '0) begin
      left_q <= left_q - PW'(1);
    end
  end

  assign pulse = (left_q != '0);

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter logic [15:0] UNLOCK_KEY = 16'hE551,
  parameter int          PULSE_LEN  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic        tick,
  input  logic        mod_en,
  input  logic        clk_en,
  output logic        rst_out
);

  logic             unlocked;
  logic [CNT_W-1:0] load_val;
  logic             run;
  logic             arm;
  logic             start;
  logic             gate_ok;
  logic [CNT_W-1:0] count;
  logic             done;
  logic             expire;

  assign gate_ok = mod_en && clk_en;

  kwdt_regs #(.UNLOCK_KEY(UNLOCK_KEY)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .unlocked (unlocked),
    .load_val (load_val),
    .run      (run),
    .arm      (arm),
    .start    (start)
  );

  kwdt_countdown u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .load_val (load_val),
    .tick     (tick),
    .run      (run),
    .gate_ok  (gate_ok),
    .arm      (arm),
    .count    (count),
    .done     (done),
    .expire   (expire)
  );

  kwdt_stretch #(.PULSE_LEN(PULSE_LEN)) u_stretch (
    .clk     (clk),
    .rst_n   (rst_n),
    .trigger (expire),
    .pulse   (rst_out)
  );

endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk
  import kwdt_pkg::*;
#(
  parameter logic [15:0] UNLOCK_KEY = 16'hE551
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [15:0]      wr_data,
  input logic             mod_en,
  input logic             clk_en,
  input logic             rst_out,
  input logic             unlocked,
  input logic [CNT_W-1:0] load_val,
  input logic             run,
  input logic             start,
  input logic             expire,
  input logic [CNT_W-1:0] count
);

  // R7
  expire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> rst_out);

  // R7
  pulse_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> $past(expire));

  // R3
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && wr_en && wr_addr != REG_GUARD) |=> ($stable(load_val) && $stable(run)));

  // R2
  guard_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_GUARD) |=> (unlocked == ($past(wr_data) == UNLOCK_KEY)));

  // R6
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(mod_en && clk_en) && !start) |=> $stable(count));

  // R8
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !expire);

endmodule

bind kwdt_top kwdt_chk #(.UNLOCK_KEY(UNLOCK_KEY)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .mod_en   (mod_en),
  .clk_en   (clk_en),
  .rst_out  (rst_out),
  .unlocked (unlocked),
  .load_val (load_val),
  .run      (run),
  .start    (start),
  .expire   (expire),
  .count    (count)
);

// File: tb/kwdt_top_tb.sv
module kwdt_top_tb;

  localparam int          PLEN = 4;
  localparam logic [15:0] KEY  = 16'hE551;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        tick = 1'b0;
  logic        mod_en = 1'b1;
  logic        clk_en = 1'b1;
  logic        rst_out;

  int total = 0;
  int bad   = 0;
  int hi_cnt = 0;
  string cur_req = "R1";

  // reference model state
  bit      m_unl, m_run, m_arm, m_done, m_st, m_fire;
  longint  m_lo, m_hi, m_cnt;
  int      m_pulse;

  always #5 clk = ~clk;

  kwdt_top #(.UNLOCK_KEY(KEY), .PULSE_LEN(PLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick(tick), .mod_en(mod_en), .clk_en(clk_en), .rst_out(rst_out)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_unl = 0; m_run = 0; m_arm = 0; m_done = 0;
      m_lo = 0; m_hi = 0; m_cnt = 0; m_pulse = 0;
    end else begin
      m_fire = 0;
      m_st = wr_en && wr_addr == 2'd3 && m_unl && wr_data[1] && !m_run;
      if (m_st) begin
        m_cnt  = m_hi * 65536 + m_lo;
        m_done = 0;
      end else if (tick && m_run && mod_en && clk_en && !m_done) begin
        if (m_cnt <= 1) begin
          m_cnt = 0; m_done = 1; m_fire = m_arm;
        end else begin
          m_cnt = m_cnt - 1;
        end
      end
      if (m_fire) m_pulse = PLEN;
      else if (m_pulse > 0) m_pulse = m_pulse - 1;
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_unl = (wr_data == KEY);
          2'd1: if (m_unl) m_lo = wr_data;
          2'd2: if (m_unl) m_hi = wr_data;
          default: if (m_unl) begin m_run = wr_data[1]; m_arm = wr_data[3]; end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      total++;
      if (rst_out !== (m_pulse > 0)) begin
        bad++;
        $display("FAIL %s: rst_out act=%0d exp=%0d at %0t", cur_req, rst_out, (m_pulse > 0), $time);
      end
      if (rst_out) hi_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n, input int period);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = ((i % period) == period - 1);
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rst_out == 1'b0, "R1", rst_out, 0);
    rst_n = 1'b1;

    // R1 / R3: block comes up locked, config writes ignored
    cur_req = "R3";
    wr(2'd1, 16'd3); wr(2'd3, 16'h000A);
    hi_cnt = 0; idle(30, 1);
    chk(hi_cnt == 0, "R3", hi_cnt, 0);

    // R2 / R7: unlock, short countdown gives one pulse of PLEN
    cur_req = "R7";
    wr(2'd0, KEY); wr(2'd1, 16'd3); wr(2'd2, 16'd0);
    hi_cnt = 0; wr(2'd3, 16'h000A); idle(20, 1);
    chk(hi_cnt == PLEN, "R7", hi_cnt, PLEN);

    // R9: no second pulse after expiry
    cur_req = "R9";
    hi_cnt = 0; idle(100, 1);
    chk(hi_cnt == 0, "R9", hi_cnt, 0);

    // R2: relock with wrong key, stop write ignored
    cur_req = "R2";
    wr(2'd3, 16'h0000); wr(2'd1, 16'd10); wr(2'd3, 16'h000A);
    wr(2'd0, 16'h1234); wr(2'd3, 16'h0000);
    hi_cnt = 0; idle(30, 1);
    chk(hi_cnt == PLEN, "R2", hi_cnt, PLEN);

    // R6: each gate pauses the countdown
    cur_req = "R6";
    wr(2'd0, KEY); wr(2'd3, 16'h0000); wr(2'd1, 16'd5);
    @(negedge clk); mod_en = 1'b0;
    wr(2'd3, 16'h000A);
    hi_cnt = 0; idle(30, 1);
    chk(hi_cnt == 0, "R6", hi_cnt, 0);
    mod_en = 1'b1; clk_en = 1'b0;
    idle(30, 1);
    chk(hi_cnt == 0, "R6", hi_cnt, 0);
    clk_en = 1'b1;
    idle(20, 1);
    chk(hi_cnt == PLEN, "R6", hi_cnt, PLEN);

    // R8: clearing run mid-count stops it
    cur_req = "R8";
    wr(2'd3, 16'h0000); wr(2'd1, 16'd8); wr(2'd3, 16'h000A);
    idle(3, 1); wr(2'd3, 16'h0008);
    hi_cnt = 0; idle(50, 1);
    chk(hi_cnt == 0, "R8", hi_cnt, 0);

    // R4: re-setting run while running does not reload (sparse ticks)
    cur_req = "R4";
    wr(2'd3, 16'h0000); wr(2'd1, 16'd6); wr(2'd3, 16'h000A);
    idle(9, 3);
    wr(2'd1, 16'd40); wr(2'd3, 16'h000A);
    hi_cnt = 0; idle(30, 3);
    chk(hi_cnt == PLEN, "R4", hi_cnt, PLEN);

    // R7: expiry without reset-enable gives no pulse
    cur_req = "R7";
    wr(2'd3, 16'h0000); wr(2'd1, 16'd2); wr(2'd3, 16'h0002);
    hi_cnt = 0; idle(20, 1);
    chk(hi_cnt == 0, "R7", hi_cnt, 0);

    // R5: zero reload expires on first tick
    cur_req = "R5";
    wr(2'd3, 16'h0000); wr(2'd1, 16'd0); wr(2'd2, 16'd0);
    hi_cnt = 0; wr(2'd3, 16'h000A); idle(10, 1);
    chk(hi_cnt == PLEN, "R5", hi_cnt, PLEN);

    // R4: high half takes part: {1,2} = 65538 ticks
    cur_req = "R4";
    wr(2'd3, 16'h0000); wr(2'd1, 16'd2); wr(2'd2, 16'd1);
    hi_cnt = 0; wr(2'd3, 16'h000A); idle(65000, 1);
    chk(hi_cnt == 0, "R4", hi_cnt, 0);
    idle(1000, 1);
    chk(hi_cnt == PLEN, "R4", hi_cnt, PLEN);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule